// File: doc/BRIEF.md
# Newton-Raphson reciprocal divider

This block divides one unsigned fraction by another. It multiplies the dividend by an estimate of the divisor's reciprocal. The divisor is a normalized fraction in [1/2, 1), so its top bit is always one. A small table is filled at elaboration and indexed by the divisor bits that follow the leading one. The table gives a first reciprocal estimate, which a fixed number of Newton-Raphson steps of the form x <- x*(2 - D*x) then refine. Each step roughly doubles the number of correct bits. A final multiply by the dividend gives the quotient estimate.

A single truncating multiplier is shared by every product. The term 2 - D*x is formed by bit inversion, so no carry chain is needed. The caller pulses `start` with both operands present. Some cycles later the block raises `done` for one cycle and presents the reciprocal and quotient estimates, which it keeps until the next result. The results are estimates within a small ulp bound and are not correctly rounded.

Top module: `nr_recip_div`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `recip` and `quot` are all zero until the first result.
- R2: A `start` seen while idle is accepted on that clock edge. `done` rises exactly 2*ITERS+1 clock edges later (5 with the default parameters) and stays high for exactly one cycle.
- R3: `recip` holds the reciprocal with two integer bits and W fraction bits (value = recip/2^W). It is within 2 of floor(2^(2W)/Dint), where Dint is the divisor taken as an integer.
- R4: `quot` holds the quotient with one integer bit and W fraction bits (value = quot/2^W). It is within 2 of floor(Nint*2^W/Dint). The internal final product never sets its second integer bit.
- R5: The first estimate comes from a table indexed by divisor bits [W-2 : W-1-J], the J bits below the leading one. Entry k holds the reciprocal of the midpoint of interval k, rounded to SF fraction bits, and lies in [1, 2]. Divisors at both ends of every interval meet R3.
- R6: Each refinement forms the correction term as the bit inversion of D*x, keeping one integer bit and F fraction bits. The D*x product always stays below 2.
- R7: A `start` pulse that arrives while a division is in progress is ignored. The running result and its `done` timing are unchanged, and no extra `done` follows.
- R8: Between `done` pulses, `recip` and `quot` hold their values whatever `divisor` and `dividend` do.
- R9: Divisor 0x8000 (0.5) gives `recip` within 2 of 2^(W+1), and divisor 0xFFFF gives `recip` within 2 of 65537. The quotient stays within the R4 bound for dividends 0 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division; sampled only while idle |
| divisor | input | W | Normalized divisor fraction, top bit one |
| dividend | input | W | Dividend fraction |
| recip | output | W+2 | Reciprocal estimate, two integer bits |
| quot | output | W+1 | Quotient estimate, one integer bit |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions rely on the divisor's top bit being one. Without it, the product D*x could reach 2, and the range checks on the seed, the correction term and the final product would no longer hold. Every divisor the stimulus draws is built by forcing that bit, whether random, at interval edges or at the extremes, while dividends use the full range. The latency assertion also assumes that `start` stays low or is ignored while a division is running, which the bench confirms with a deliberate mid-run pulse.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MUL_D = 2'd1,
    ST_MUL_X = 2'd2,
    ST_FINAL = 2'd3
  } nr_state_e;

  // Reciprocal of the midpoint of interval k out of 2^j over [0.5,1),
  // scaled by 2^sf and rounded to nearest.
  function automatic longint nr_seed_word(input int k, input int j, input int sf);
    longint num;
    longint den;
    longint twice;
    num   = longint'(1) << (sf + j + 3);
    den   = (longint'(1) << (j + 1)) + longint'(2 * k + 1);
    twice = num / den;
    return (twice + 1) >>> 1;
  endfunction

  // Number of refinements needed for the seed precision to reach target bits.
  function automatic int nr_iter_count(input int j, input int target);
    int bits;
    int n;
    bits = (j == 0) ? 1 : j + 1;
    n = 0;
    while (bits < target) begin
      bits = bits * 2;
      n = n + 1;
    end
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/nr_seed_rom.sv
module nr_seed_rom #(
  parameter int W  = 16,
  parameter int J  = 5,
  parameter int SF = 8
) (
  input  logic [W-1:0]  div_in,
  output logic [SF+1:0] seed_out
);
  import nr_div_pkg::*;

  localparam int SWW = SF + 2;

  generate
    if (J == 0) begin : g_unit
      // No table: first estimate is exactly one.
      logic unused_div;
      assign unused_div = ^div_in;
      assign seed_out = SWW'(longint'(1) << SF);
    end else begin : g_table
      localparam int ENTRIES = 1 << J;
      logic [SWW-1:0] tbl [ENTRIES];
      for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
        assign tbl[k] = SWW'(nr_seed_word(k, J, SF));
      end
      logic [J-1:0] idx;
      assign idx = div_in[W-2 -: J];
      logic unused_div;
      assign unused_div = ^{div_in[W-1], div_in[W-2-J:0]};
      assign seed_out = tbl[idx];
    end
  endgenerate

endmodule

// File: rtl/nr_mul.sv
module nr_mul #(
  parameter int AW = 22,
  parameter int SH = 20
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [AW-1:0] y
);
  localparam int PW = 2 * AW;

  logic [PW-1:0] full;
  assign full = PW'(a) * PW'(b);
  // Keep AW bits starting at the binary point; the rest is truncated.
  assign y = full[SH +: AW];

  logic unused_bits;
  assign unused_bits = ^{full[SH-1:0], full[PW-1:SH+AW]};

endmodule

// File: rtl/nr_div_ctrl.sv
module nr_div_ctrl #(
  parameter int ITERS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic do_p,
  output logic do_x,
  output logic do_fin
);
  import nr_div_pkg::*;

  localparam int ITW = $clog2(ITERS) + 1;

  nr_state_e        state_q;
  nr_state_e        state_d;
  logic [ITW-1:0]   it_q;
  logic [ITW-1:0]   it_d;
  logic             last_iter;

  assign accept    = (state_q == ST_IDLE) && start;
  assign do_p      = (state_q == ST_MUL_D);
  assign do_x      = (state_q == ST_MUL_X);
  assign do_fin    = (state_q == ST_FINAL);
  assign last_iter = (it_q == ITW'(ITERS - 1));

  always_comb begin
    state_d = state_q;
    it_d    = it_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_MUL_D;
          it_d    = '0;
        end
      end
      ST_MUL_D: state_d = ST_MUL_X;
      ST_MUL_X: begin
        if (last_iter) begin
          state_d = ST_FINAL;
        end else begin
          state_d = ST_MUL_D;
          it_d    = it_q + 1'b1;
        end
      end
      ST_FINAL: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      it_q    <= '0;
    end else begin
      state_q <= state_d;
      it_q    <= it_d;
    end
  end

endmodule

// File: rtl/nr_recip_div.sv
module nr_recip_div #(
  parameter int W         = 16,
  parameter int SEED_IDX  = 5,
  parameter int SEED_FRAC = 8,
  parameter int GUARD     = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   divisor,
  input  logic [W-1:0]   dividend,
  output logic [W+1:0]   recip,
  output logic [W:0]     quot,
  output logic           done
);
  import nr_div_pkg::*;

  localparam int F     = W + GUARD;
  localparam int XW    = F + 2;
  localparam int ITERS = nr_iter_count(SEED_IDX, F);
  localparam int LAT   = 2 * ITERS + 1;

  // Named internal events, observed by the bound checker.
  logic accept;
  logic do_p;
  logic do_x;
  logic do_fin;
  logic dx_over;
  logic fin_over;
  logic [SEED_FRAC+1:0] seed_x;

  logic [F-1:0]  d_q;
  logic [F-1:0]  n_q;
  logic [XW-1:0] x_q;
  logic [XW-1:0] p_q;
  logic [F:0]    corr_term;
  logic [XW-1:0] mul_a;
  logic [XW-1:0] mul_b;
  logic [XW-1:0] mul_y;
  logic [W+1:0]  recip_q;
  logic [W:0]    quot_q;
  logic          done_q;

  nr_div_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .do_p   (do_p),
    .do_x   (do_x),
    .do_fin (do_fin)
  );

  nr_seed_rom #(.W(W), .J(SEED_IDX), .SF(SEED_FRAC)) u_seed (
    .div_in   (divisor),
    .seed_out (seed_x)
  );

  // 2 - D*x by inversion of the low F+1 bits (one ulp short, no carry).
  assign corr_term = ~p_q[F:0];
  assign dx_over   = p_q[F+1];

  // Operand routing for the shared multiplier.
  assign mul_a = do_fin ? {2'b00, n_q} : x_q;
  assign mul_b = do_p   ? {2'b00, d_q} :
                 do_fin ? x_q          : {1'b0, corr_term};

  nr_mul #(.AW(XW), .SH(F)) u_mul (
    .a (mul_a),
    .b (mul_b),
    .y (mul_y)
  );

  assign fin_over = mul_y[F+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_q     <= '0;
      n_q     <= '0;
      x_q     <= '0;
      p_q     <= '0;
      recip_q <= '0;
      quot_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= do_fin;
      if (accept) begin
        d_q <= {divisor,  {GUARD{1'b0}}};
        n_q <= {dividend, {GUARD{1'b0}}};
        x_q <= {seed_x, {(F - SEED_FRAC){1'b0}}};
      end
      if (do_p) p_q <= mul_y;
      if (do_x) x_q <= mul_y;
      if (do_fin) begin
        recip_q <= x_q[F+1:GUARD];
        quot_q  <= mul_y[F:GUARD];
      end
    end
  end

  assign recip = recip_q;
  assign quot  = quot_q;
  assign done  = done_q;

endmodule

// File: rtl/nr_recip_div_chk.sv
module nr_recip_div_chk #(
  parameter int W   = 16,
  parameter int SF  = 8,
  parameter int LAT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          do_x,
  input logic          do_fin,
  input logic          dx_over,
  input logic          fin_over,
  input logic [SF+1:0] seed_x,
  input logic [W+1:0]  recip,
  input logic [W:0]    quot,
  input logic          done
);
  localparam int CW = $clog2(LAT + 2) + 1;

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (done) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (active && cnt == CW'(LAT)));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !active);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(recip) && $stable(quot)));

  // R6
  dx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_x |-> !dx_over);

  // R4
  quot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_fin |-> !fin_over);

  // R5
  seed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (seed_x >= (SF+2)'(1 << SF) && seed_x <= (SF+2)'(2 << SF)));

  // R3
  recip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (recip <= (W+2)'(2 << W) && recip[W+1:W] != 2'b00));

endmodule

bind nr_recip_div nr_recip_div_chk #(.W(W), .SF(SEED_FRAC), .LAT(LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .do_x     (do_x),
  .do_fin   (do_fin),
  .dx_over  (dx_over),
  .fin_over (fin_over),
  .seed_x   (seed_x),
  .recip    (recip),
  .quot     (quot),
  .done     (done)
);

// File: tb/tb_nr_recip_div.sv
`timescale 1ns/1ps
module tb_nr_recip_div;

  localparam int W   = 16;
  localparam int J   = 5;
  localparam int LAT = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  divisor = '0;
  logic [W-1:0]  dividend = '0;
  logic [W+1:0]  recip;
  logic [W:0]    quot;
  logic          done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nr_recip_div dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .divisor(divisor), .dividend(dividend),
    .recip(recip), .quot(quot), .done(done)
  );

  function automatic longint exp_recip(input longint d);
    return (longint'(1) << (2 * W)) / d;
  endfunction

  function automatic longint exp_quot(input longint n, input longint d);
    return (n << W) / d;
  endfunction

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_near(input string tag, input longint act, input longint exp);
    longint diff;
    diff = act - exp;
    check(tag, (diff <= 2) && (diff >= -2), act, exp);
  endtask

  // Launch one division and wait for done, sampling at falling edges.
  task automatic run_op(input logic [W-1:0] d, input logic [W-1:0] n, output int cyc);
    @(negedge clk);
    divisor = d; dividend = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic div_and_check(input string tag, input logic [W-1:0] d, input logic [W-1:0] n);
    int cyc;
    run_op(d, n, cyc);
    check_near({tag, " recip"}, longint'(recip), exp_recip(longint'(d)));
    check_near({tag, " quot"},  longint'(quot),  exp_quot(longint'(n), longint'(d)));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [W+1:0] r_hold;
    logic [W:0]   q_hold;
    bit extra;
    void'($urandom(32'd4242));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 done in reset", done == 1'b0, done, 0);
    check("R1 recip in reset", recip == '0, recip, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 quot after reset", quot == '0, quot, 0);
    check("R1 done after reset", done == 1'b0, done, 0);

    // R2: latency and pulse width
    run_op(16'hC000, 16'h6800, cyc);
    check("R2 latency", cyc == LAT + 1, cyc - 1, LAT);
    check_near("R3 recip 0.75", longint'(recip), exp_recip(64'hC000));
    check_near("R4 quot 0.40625/0.75", longint'(quot), exp_quot(64'h6800, 64'hC000));
    @(negedge clk);
    check("R2 pulse width", done == 1'b0, done, 0);

    // R9: corner divisors and dividends
    div_and_check("R9 d=0.5 n=max", 16'h8000, 16'hFFFF);
    div_and_check("R9 d=0.5 n=0", 16'h8000, 16'h0000);
    div_and_check("R9 d=max n=max", 16'hFFFF, 16'hFFFF);
    div_and_check("R9 d=max n=0", 16'hFFFF, 16'h0000);
    div_and_check("R9 n=d", 16'hA5A5, 16'hA5A5);
    div_and_check("R9 d=max n=1", 16'hFFFF, 16'h0001);

    // R5: both ends of every seed interval
    for (int k = 0; k < (1 << J); k++) begin
      logic [W-1:0] lo;
      lo = 16'h8000 + 16'(k << (W - 1 - J));
      div_and_check("R5 interval low", lo, 16'h7FFF);
      div_and_check("R5 interval high", lo + 16'((1 << (W - 1 - J)) - 1), 16'hFFFE);
    end

    // R8: outputs hold while inputs move
    run_op(16'h9ABC, 16'h1234, cyc);
    r_hold = recip; q_hold = quot;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      divisor = 16'(16'h8000 | $urandom()); dividend = 16'($urandom());
    end
    check("R8 recip held", recip == r_hold, recip, r_hold);
    check("R8 quot held", quot == q_hold, quot, q_hold);

    // R7: start during a running division is ignored
    @(negedge clk);
    divisor = 16'hE000; dividend = 16'h3000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    divisor = 16'h8001; dividend = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 3;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    check("R7 latency unchanged", cyc == LAT + 1, cyc - 1, LAT);
    check_near("R7 recip first op", longint'(recip), exp_recip(64'hE000));
    check_near("R7 quot first op", longint'(quot), exp_quot(64'h3000, 64'hE000));
    extra = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    check("R7 no extra done", extra == 1'b0, extra, 0);

    // R3 R4 R6: random operands
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] d;
      logic [W-1:0] n;
      d = 16'(16'h8000 | $urandom());
      n = 16'($urandom());
      div_and_check("R3 R4 R6 random", d, n);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule